// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO with Bypass

This block sits between two independently clocked ports, A and B, and buffers 18-bit words in both directions at once. Two separate first-in first-out memories live inside it: one carries traffic from A to B, the other from B to A. At each port a single enable qualifies every transfer, and a read/write line picks whether that transfer pushes into the outgoing memory or pops from the incoming one. Read data lands in a per-port output register. A registered drive-enable, which follows the port's output-enable, tells the surrounding pad logic when to drive the data lines.

Each direction reports full and almost-full in its writer's clock domain, and empty and almost-empty in its reader's clock domain. The almost thresholds can be programmed per direction through a small register window on port A, selected by a chip select and a 3-bit address. The same window holds a bypass control. When bypass is on for a direction, a read at the far port copies the near port's input register straight into the output register, and that direction's memory is left untouched. Pointers cross clock domains as Gray code through two-flop synchronizers, so each flag errs on the safe side for a few cycles.

Top module: `bififo_top`

## Requirements
- R1: After the active-low master reset, both directions show empty=1, almost-empty=1, full=0 and almost-full=0. Both output registers read 0, all four offset registers read 8, and the bypass control reads 0.
- R2: With bypass off, a transfer at A with enA=1, csA=0, rwA=0 stores dinA in the A-to-B memory. A transfer at B with enB=1, rwB=1 loads the oldest stored word into doutB. Words leave in the order they were written.
- R3: With bypass off, a transfer at B with rwB=0 stores dinB in the B-to-A memory. A transfer at A with csA=0 and rwA=1 delivers those words to doutA in the order they were written.
- R4: A write into a direction that shows full is ignored. The stored words and their count stay unchanged.
- R5: A read from a direction that shows empty is ignored. The output register keeps its previous value and the read pointer does not move.
- R6: Full asserts once the direction holds DEPTH words, and empty once it holds none; full implies almost-full and empty implies almost-empty.
- R7: With N words held, almost-full is 1 exactly when N >= DEPTH - afOffset, and almost-empty is 1 exactly when N <= aeOffset.
- R8: With enA=1 and csA=1, port A accesses a register instead of a memory. rwA=0 writes dinA and rwA=1 loads the register into doutA. Address 0 holds the A-to-B almost-empty offset, 1 the A-to-B almost-full offset, 2 the B-to-A almost-empty offset and 3 the B-to-A almost-full offset, each in the low log2(DEPTH) bits. Address 4 holds the bypass control. Other addresses read 0.
- R9: When bypass-control bit 0 is 1, writes at A update only A's input register. A read at B loads that register into doutB, and the A-to-B memory is left unchanged.
- R10: When bypass-control bit 1 is 1, writes at B update only B's input register. A read at A loads that register into doutA, and the B-to-A memory is left unchanged.
- R11: doeA and doeB each equal their port's output-enable as sampled at the previous edge of that port's clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port A clock |
| clkB | input | 1 | Port B clock |
| rstN | input | 1 | Master reset, active low, asynchronous |
| enA | input | 1 | Port A transfer enable |
| rwA | input | 1 | Port A direction: 0 write, 1 read |
| oeA | input | 1 | Port A output-enable |
| csA | input | 1 | Port A register window select |
| addrA | input | 3 | Port A register address |
| dinA | input | 18 | Port A write data |
| doutA | output | 18 | Port A output register |
| doeA | output | 1 | Port A drive-enable |
| enB | input | 1 | Port B transfer enable |
| rwB | input | 1 | Port B direction: 0 write, 1 read |
| oeB | input | 1 | Port B output-enable |
| dinB | input | 18 | Port B write data |
| doutB | output | 18 | Port B output register |
| doeB | output | 1 | Port B drive-enable |
| fullAB | output | 1 | A-to-B full (clkA domain) |
| almostFullAB | output | 1 | A-to-B almost-full (clkA domain) |
| emptyAB | output | 1 | A-to-B empty (clkB domain) |
| almostEmptyAB | output | 1 | A-to-B almost-empty (clkB domain) |
| fullBA | output | 1 | B-to-A full (clkB domain) |
| almostFullBA | output | 1 | B-to-A almost-full (clkB domain) |
| emptyBA | output | 1 | B-to-A empty (clkA domain) |
| almostEmptyBA | output | 1 | B-to-A almost-empty (clkA domain) |

## Verification
The assertions take it that the offset registers and the bypass control are changed only while both directions are idle, and that an input register is not rewritten while the opposite port performs a bypass read. Those values are sampled across clock domains without synchronizers. The stimulus keeps to this by writing configuration only between operations and by waiting several cycles of both clocks after every operation. It then compares flags with the bench model, so the two-flop synchronizer delay never shows up as a mismatch. Random traffic uses only the memory path; bypass is exercised in directed steps.

// File: rtl/bififo_pkg.sv
package bififo_pkg;

  // Per-port strobes from control to datapath, valid for one clock edge.
  typedef struct packed {
    logic capture;   // load the port's input register
    logic push;      // push into the outgoing memory
    logic pop;       // pop from the incoming memory
    logic bypassRd;  // copy the opposite input register to the output
    logic cfgRd;     // load register window data into the output
  } portStb_t;

  localparam logic [2:0] ADDR_AE_AB = 3'd0;
  localparam logic [2:0] ADDR_AF_AB = 3'd1;
  localparam logic [2:0] ADDR_AE_BA = 3'd2;
  localparam logic [2:0] ADDR_AF_BA = 3'd3;
  localparam logic [2:0] ADDR_BYP   = 3'd4;

  localparam int DIR_AB = 0;
  localparam int DIR_BA = 1;

endpackage

// File: rtl/bififo_chan.sv
// One direction: memory, Gray pointers, synchronizers and the four flags.
module bififo_chan #(
  parameter int W     = 18,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clkW,
  input  logic          clkR,
  input  logic          rstN,
  input  logic          pushReq,
  input  logic [W-1:0]  wrData,
  input  logic          popReq,
  input  logic [AW-1:0] aeOff,
  input  logic [AW-1:0] afOff,
  output logic [W-1:0]  rdWord,
  output logic          popOk,
  output logic          full,
  output logic          almostFull,
  output logic          empty,
  output logic          almostEmpty
);
  localparam int PW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wBin, wGray, rBin, rGray;
  logic [PW-1:0] rSync1, rSync2, wSync1, wSync2;
  logic [PW-1:0] wCount, rCount;
  logic          pushOk;

  function automatic logic [PW-1:0] grayToBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] binToGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  assign pushOk = pushReq & ~full;
  assign popOk  = popReq & ~empty;

  // write domain
  always_ff @(posedge clkW or negedge rstN) begin
    if (!rstN) begin
      wBin   <= '0;
      wGray  <= '0;
      rSync1 <= '0;
      rSync2 <= '0;
    end else begin
      rSync1 <= rGray;
      rSync2 <= rSync1;
      if (pushOk) begin
        wBin  <= wBin + 1'b1;
        wGray <= binToGray(wBin + 1'b1);
      end
    end
  end

  always_ff @(posedge clkW) begin
    if (pushOk) mem[wBin[AW-1:0]] <= wrData;
  end

  // read domain
  always_ff @(posedge clkR or negedge rstN) begin
    if (!rstN) begin
      rBin   <= '0;
      rGray  <= '0;
      wSync1 <= '0;
      wSync2 <= '0;
    end else begin
      wSync1 <= wGray;
      wSync2 <= wSync1;
      if (popOk) begin
        rBin  <= rBin + 1'b1;
        rGray <= binToGray(rBin + 1'b1);
      end
    end
  end

  assign rdWord = mem[rBin[AW-1:0]];

  assign full       = (wGray == {~rSync2[PW-1:PW-2], rSync2[PW-3:0]});
  assign wCount     = wBin - grayToBin(rSync2);
  assign almostFull = (wCount >= (PW'(DEPTH) - {1'b0, afOff}));

  assign empty       = (rGray == wSync2);
  assign rCount      = grayToBin(wSync2) - rBin;
  assign almostEmpty = (rCount <= {1'b0, aeOff});

  // R4: the writer never sees more than DEPTH words outstanding
  p_no_overflow_r4: assert property (@(posedge clkW) disable iff (!rstN)
    wCount <= PW'(DEPTH));

  // R5: the read pointer holds while empty
  p_no_underflow_r5: assert property (@(posedge clkR) disable iff (!rstN)
    empty |=> $stable(rBin));

  // R6: flag implications
  p_full_af_r6: assert property (@(posedge clkW) disable iff (!rstN)
    full |-> almostFull);
  p_empty_ae_r6: assert property (@(posedge clkR) disable iff (!rstN)
    empty |-> almostEmpty);

  // R2: the write-side Gray pointer changes at most one bit per edge
  p_gray_step_r2: assert property (@(posedge clkW) disable iff (!rstN)
    $onehot0(wGray ^ $past(wGray)));

endmodule

// File: rtl/bififo_ctrl.sv
// Port decode, register window and bypass control.
module bififo_ctrl
  import bififo_pkg::*;
#(
  parameter int W     = 18,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                clkA,
  input  logic                rstN,
  input  logic                enA,
  input  logic                rwA,
  input  logic                csA,
  input  logic [2:0]          addrA,
  input  logic [W-1:0]        dinA,
  input  logic                enB,
  input  logic                rwB,
  output portStb_t            stbA,
  output portStb_t            stbB,
  output logic [W-1:0]        cfgRdData,
  output logic [1:0][AW-1:0]  aeOff,
  output logic [1:0][AW-1:0]  afOff
);
  localparam logic [AW-1:0] OFF_RESET = AW'(8);

  logic [1:0] bypass;   // bit 0: A to B, bit 1: B to A
  logic       fifoA, regA, regWr;

  assign fifoA = enA & ~csA;
  assign regA  = enA & csA;
  assign regWr = regA & ~rwA;

  always_comb begin
    stbA.capture  = fifoA & ~rwA;
    stbA.push     = fifoA & ~rwA & ~bypass[DIR_AB];
    stbA.pop      = fifoA &  rwA & ~bypass[DIR_BA];
    stbA.bypassRd = fifoA &  rwA &  bypass[DIR_BA];
    stbA.cfgRd    = regA  &  rwA;

    stbB.capture  = enB & ~rwB;
    stbB.push     = enB & ~rwB & ~bypass[DIR_BA];
    stbB.pop      = enB &  rwB & ~bypass[DIR_AB];
    stbB.bypassRd = enB &  rwB &  bypass[DIR_AB];
    stbB.cfgRd    = 1'b0;
  end

  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN) begin
      aeOff  <= {OFF_RESET, OFF_RESET};
      afOff  <= {OFF_RESET, OFF_RESET};
      bypass <= '0;
    end else if (regWr) begin
      unique case (addrA)
        ADDR_AE_AB: aeOff[DIR_AB] <= dinA[AW-1:0];
        ADDR_AF_AB: afOff[DIR_AB] <= dinA[AW-1:0];
        ADDR_AE_BA: aeOff[DIR_BA] <= dinA[AW-1:0];
        ADDR_AF_BA: afOff[DIR_BA] <= dinA[AW-1:0];
        ADDR_BYP:   bypass        <= dinA[1:0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    cfgRdData = '0;
    unique case (addrA)
      ADDR_AE_AB: cfgRdData[AW-1:0] = aeOff[DIR_AB];
      ADDR_AF_AB: cfgRdData[AW-1:0] = afOff[DIR_AB];
      ADDR_AE_BA: cfgRdData[AW-1:0] = aeOff[DIR_BA];
      ADDR_AF_BA: cfgRdData[AW-1:0] = afOff[DIR_BA];
      ADDR_BYP:   cfgRdData[1:0]    = bypass;
      default:    ;
    endcase
  end

  // R8: a register write lands in the addressed offset
  p_offset_write_r8: assert property (@(posedge clkA) disable iff (!rstN)
    (regWr && addrA == ADDR_AE_AB) |=> aeOff[DIR_AB] == $past(dinA[AW-1:0]));

  // R9: the bypass control takes the written bits
  p_bypass_write_r9: assert property (@(posedge clkA) disable iff (!rstN)
    (regWr && addrA == ADDR_BYP) |=> bypass == $past(dinA[1:0]));

  // R8: at most one action per port per edge
  p_one_action_r8: assert property (@(posedge clkA) disable iff (!rstN)
    $onehot0({stbA.push, stbA.pop, stbA.bypassRd, stbA.cfgRd}));

endmodule

// File: rtl/bififo_path.sv
// Input/output registers, drive enables and the two direction channels.
module bififo_path
  import bififo_pkg::*;
#(
  parameter int W     = 18,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                clkA,
  input  logic                clkB,
  input  logic                rstN,
  input  portStb_t            stbA,
  input  portStb_t            stbB,
  input  logic [W-1:0]        dinA,
  input  logic [W-1:0]        dinB,
  input  logic                oeA,
  input  logic                oeB,
  input  logic [W-1:0]        cfgRdData,
  input  logic [1:0][AW-1:0]  aeOff,
  input  logic [1:0][AW-1:0]  afOff,
  output logic [W-1:0]        doutA,
  output logic [W-1:0]        doutB,
  output logic                doeA,
  output logic                doeB,
  output logic [1:0]          full,
  output logic [1:0]          almostFull,
  output logic [1:0]          empty,
  output logic [1:0]          almostEmpty
);
  logic [W-1:0] inA, inB;
  logic         clkWr [2];
  logic         clkRd [2];
  logic         pushReq [2];
  logic         popReq [2];
  logic [W-1:0] wrData [2];
  logic [W-1:0] rdWord [2];
  logic [1:0]   popOk;

  assign clkWr[DIR_AB]   = clkA;
  assign clkRd[DIR_AB]   = clkB;
  assign pushReq[DIR_AB] = stbA.push;
  assign popReq[DIR_AB]  = stbB.pop;
  assign wrData[DIR_AB]  = dinA;
  assign clkWr[DIR_BA]   = clkB;
  assign clkRd[DIR_BA]   = clkA;
  assign pushReq[DIR_BA] = stbB.push;
  assign popReq[DIR_BA]  = stbA.pop;
  assign wrData[DIR_BA]  = dinB;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    bififo_chan #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_chan (
      .clkW        (clkWr[d]),
      .clkR        (clkRd[d]),
      .rstN        (rstN),
      .pushReq     (pushReq[d]),
      .wrData      (wrData[d]),
      .popReq      (popReq[d]),
      .aeOff       (aeOff[d]),
      .afOff       (afOff[d]),
      .rdWord      (rdWord[d]),
      .popOk       (popOk[d]),
      .full        (full[d]),
      .almostFull  (almostFull[d]),
      .empty       (empty[d]),
      .almostEmpty (almostEmpty[d])
    );
  end

  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN) begin
      inA   <= '0;
      doutA <= '0;
      doeA  <= 1'b0;
    end else begin
      doeA <= oeA;
      if (stbA.capture) inA <= dinA;
      if (stbA.cfgRd)             doutA <= cfgRdData;
      else if (stbA.bypassRd)     doutA <= inB;
      else if (popOk[DIR_BA])     doutA <= rdWord[DIR_BA];
    end
  end

  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN) begin
      inB   <= '0;
      doutB <= '0;
      doeB  <= 1'b0;
    end else begin
      doeB <= oeB;
      if (stbB.capture) inB <= dinB;
      if (stbB.cfgRd)             doutB <= '0;
      else if (stbB.bypassRd)     doutB <= inA;
      else if (popOk[DIR_AB])     doutB <= rdWord[DIR_AB];
    end
  end

  // R5: a read at B while A-to-B is empty leaves doutB alone
  p_hold_on_empty_r5: assert property (@(posedge clkB) disable iff (!rstN)
    (stbB.pop && empty[DIR_AB]) |=> $stable(doutB));

  // R9: a bypass read at B returns A's input register
  p_bypass_ab_r9: assert property (@(posedge clkB) disable iff (!rstN)
    stbB.bypassRd |=> doutB == $past(inA));

  // R10: a bypass read at A returns B's input register
  p_bypass_ba_r10: assert property (@(posedge clkA) disable iff (!rstN)
    stbA.bypassRd |=> doutA == $past(inB));

  // R11: drive enables trail the output-enables by one edge
  p_doe_a_r11: assert property (@(posedge clkA) disable iff (!rstN)
    1'b1 |=> doeA == $past(oeA));
  p_doe_b_r11: assert property (@(posedge clkB) disable iff (!rstN)
    1'b1 |=> doeB == $past(oeB));

endmodule

// File: rtl/bififo_top.sv
module bififo_top
  import bififo_pkg::*;
#(
  parameter int W     = 18,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic         clkA,
  input  logic         clkB,
  input  logic         rstN,
  input  logic         enA,
  input  logic         rwA,
  input  logic         oeA,
  input  logic         csA,
  input  logic [2:0]   addrA,
  input  logic [W-1:0] dinA,
  output logic [W-1:0] doutA,
  output logic         doeA,
  input  logic         enB,
  input  logic         rwB,
  input  logic         oeB,
  input  logic [W-1:0] dinB,
  output logic [W-1:0] doutB,
  output logic         doeB,
  output logic         fullAB,
  output logic         almostFullAB,
  output logic         emptyAB,
  output logic         almostEmptyAB,
  output logic         fullBA,
  output logic         almostFullBA,
  output logic         emptyBA,
  output logic         almostEmptyBA
);
  portStb_t           stbA, stbB;
  logic [W-1:0]       cfgRdData;
  logic [1:0][AW-1:0] aeOff, afOff;
  logic [1:0]         full, almostFull, empty, almostEmpty;

  bififo_ctrl #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clkA      (clkA),
    .rstN      (rstN),
    .enA       (enA),
    .rwA       (rwA),
    .csA       (csA),
    .addrA     (addrA),
    .dinA      (dinA),
    .enB       (enB),
    .rwB       (rwB),
    .stbA      (stbA),
    .stbB      (stbB),
    .cfgRdData (cfgRdData),
    .aeOff     (aeOff),
    .afOff     (afOff)
  );

  bififo_path #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_path (
    .clkA        (clkA),
    .clkB        (clkB),
    .rstN        (rstN),
    .stbA        (stbA),
    .stbB        (stbB),
    .dinA        (dinA),
    .dinB        (dinB),
    .oeA         (oeA),
    .oeB         (oeB),
    .cfgRdData   (cfgRdData),
    .aeOff       (aeOff),
    .afOff       (afOff),
    .doutA       (doutA),
    .doutB       (doutB),
    .doeA        (doeA),
    .doeB        (doeB),
    .full        (full),
    .almostFull  (almostFull),
    .empty       (empty),
    .almostEmpty (almostEmpty)
  );

  assign fullAB        = full[DIR_AB];
  assign almostFullAB  = almostFull[DIR_AB];
  assign emptyAB       = empty[DIR_AB];
  assign almostEmptyAB = almostEmpty[DIR_AB];
  assign fullBA        = full[DIR_BA];
  assign almostFullBA  = almostFull[DIR_BA];
  assign emptyBA       = empty[DIR_BA];
  assign almostEmptyBA = almostEmpty[DIR_BA];

endmodule

// File: tb/sim_bififo_top.sv
`timescale 1ns/1ps
module sim_bififo_top;
  localparam int W = 18;
  localparam int DEPTH = 256;

  logic clkA = 0, clkB = 0, rstN = 0;
  logic enA = 0, rwA = 0, oeA = 0, csA = 0, enB = 0, rwB = 0, oeB = 0;
  logic [2:0] addrA = '0;
  logic [W-1:0] dinA = '0, dinB = '0;
  logic [W-1:0] doutA, doutB;
  logic doeA, doeB;
  logic fullAB, almostFullAB, emptyAB, almostEmptyAB;
  logic fullBA, almostFullBA, emptyBA, almostEmptyBA;

  int vectors = 0, errors = 0;
  logic [W-1:0] qAB[$], qBA[$];
  logic [W-1:0] lastA = '0, lastB = '0;
  int mAeAB = 8, mAfAB = 8, mAeBA = 8, mAfBA = 8;

  always #5 clkA = ~clkA;
  always #7 clkB = ~clkB;

  bififo_top #(.W(W), .DEPTH(DEPTH)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clkB);
    repeat (4) @(negedge clkA);
  endtask

  task automatic wrA(input logic [W-1:0] d);
    @(negedge clkA); enA = 1; rwA = 0; csA = 0; dinA = d;
    @(negedge clkA); enA = 0;
  endtask

  task automatic wrB(input logic [W-1:0] d);
    @(negedge clkB); enB = 1; rwB = 0; dinB = d;
    @(negedge clkB); enB = 0;
  endtask

  task automatic rdA(output logic [W-1:0] v);
    @(negedge clkA); enA = 1; rwA = 1; csA = 0;
    @(negedge clkA); enA = 0; v = doutA;
  endtask

  task automatic rdB(output logic [W-1:0] v);
    @(negedge clkB); enB = 1; rwB = 1;
    @(negedge clkB); enB = 0; v = doutB;
  endtask

  task automatic cfgWr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clkA); enA = 1; csA = 1; rwA = 0; addrA = a; dinA = d;
    @(negedge clkA); enA = 0; csA = 0;
  endtask

  task automatic cfgRd(input logic [2:0] a, output logic [W-1:0] v);
    @(negedge clkA); enA = 1; csA = 1; rwA = 1; addrA = a;
    @(negedge clkA); enA = 0; csA = 0; v = doutA; lastA = v;
  endtask

  function automatic bit expAf(int n, int off); return n >= DEPTH - off; endfunction
  function automatic bit expAe(int n, int off); return n <= off; endfunction

  task automatic checkFlags(input string req);
    int nAB = qAB.size(), nBA = qBA.size();
    chk({req, " fullAB"},        fullAB,        nAB == DEPTH);
    chk({req, " almostFullAB"},  almostFullAB,  expAf(nAB, mAfAB));
    chk({req, " emptyAB"},       emptyAB,       nAB == 0);
    chk({req, " almostEmptyAB"}, almostEmptyAB, expAe(nAB, mAeAB));
    chk({req, " fullBA"},        fullBA,        nBA == DEPTH);
    chk({req, " almostFullBA"},  almostFullBA,  expAf(nBA, mAfBA));
    chk({req, " emptyBA"},       emptyBA,       nBA == 0);
    chk({req, " almostEmptyBA"}, almostEmptyBA, expAe(nBA, mAeBA));
  endtask

  initial begin
    #1_500_000;
    errors++; vectors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] v, d, e;
    void'($urandom(32'd1234));
    #33 rstN = 1;
    settle();

    // R1: reset state
    checkFlags("R1");
    chk("R1 doutA", doutA, 0);
    chk("R1 doutB", doutB, 0);
    for (int a = 0; a < 4; a++) begin
      cfgRd(3'(a), v); chk("R1 offset", v, 8);
    end
    cfgRd(3'd4, v); chk("R1 bypass", v, 0);

    // R8: program and read back offsets
    cfgWr(3'd0, 18'd3); mAeAB = 3;
    cfgWr(3'd1, 18'd5); mAfAB = 5;
    cfgWr(3'd2, 18'd6); mAeBA = 6;
    cfgWr(3'd3, 18'd2); mAfBA = 2;
    cfgRd(3'd0, v); chk("R8 aeAB", v, 3);
    cfgRd(3'd1, v); chk("R8 afAB", v, 5);
    cfgRd(3'd2, v); chk("R8 aeBA", v, 6);
    cfgRd(3'd3, v); chk("R8 afBA", v, 2);
    cfgRd(3'd6, v); chk("R8 unmapped", v, 0);
    settle();
    checkFlags("R8");

    // R4 R6 R7: fill A-to-B, probing threshold edges
    for (int i = 0; i < DEPTH; i++) begin
      d = 18'(($urandom() ^ i) & 32'h3FFFF);
      wrA(d); qAB.push_back(d);
      if (i + 1 == 3 || i + 1 == 4 || i + 1 == DEPTH - 6 || i + 1 == DEPTH - 5) begin
        settle(); checkFlags("R7");
      end
    end
    settle();
    checkFlags("R6");
    wrA(18'h3FFFF);           // R4: ignored while full
    settle();
    checkFlags("R4");
    for (int i = 0; i < DEPTH; i++) begin
      rdB(v); e = qAB.pop_front(); chk("R4 drain order", v, e); lastB = v;
    end
    settle();
    checkFlags("R6 drained");
    rdB(v); chk("R5 hold on empty", v, lastB);

    // R9: bypass A to B
    cfgWr(3'd4, 18'd1);
    wrA(18'h2A5A5); settle();
    rdB(v); chk("R9 bypass data", v, 18'h2A5A5); lastB = v;
    settle(); checkFlags("R9 memory untouched");
    // R10: bypass B to A
    cfgWr(3'd4, 18'd2);
    wrB(18'h15A5A); settle();
    rdA(v); chk("R10 bypass data", v, 18'h15A5A); lastA = v;
    settle(); checkFlags("R10 memory untouched");
    cfgWr(3'd4, 18'd0);
    settle();

    // R11: drive enables
    @(negedge clkA); oeA = 1; @(negedge clkA); chk("R11 doeA high", doeA, 1);
    oeA = 0; @(negedge clkA); chk("R11 doeA low", doeA, 0);
    @(negedge clkB); oeB = 1; @(negedge clkB); chk("R11 doeB high", doeB, 1);
    oeB = 0; @(negedge clkB); chk("R11 doeB low", doeB, 0);

    // R2 R3 R5: random traffic against queue model
    for (int n = 0; n < 400; n++) begin
      case ($urandom() % 4)
        0: begin d = 18'($urandom() & 32'h3FFFF); wrA(d);
                 if (qAB.size() < DEPTH) qAB.push_back(d); end
        1: begin d = 18'($urandom() & 32'h3FFFF); wrB(d);
                 if (qBA.size() < DEPTH) qBA.push_back(d); end
        2: begin rdB(v);
                 if (qAB.size() > 0) begin e = qAB.pop_front(); chk("R2 order", v, e); end
                 else chk("R5 hold B", v, lastB);
                 lastB = v; end
        default: begin rdA(v);
                 if (qBA.size() > 0) begin e = qBA.pop_front(); chk("R3 order", v, e); end
                 else chk("R5 hold A", v, lastA);
                 lastA = v; end
      endcase
      settle();
      if (n % 8 == 7) checkFlags("R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule